// File: doc/BRIEF.md
# Repeater Expansion Bus Interface

This block joins one multiport repeater device to a shared expansion bus, so that several such devices behave as one larger repeater. When any local port is active, it requests the bus. An external arbiter grants the bus through an active-low acknowledge. The device that both requests and is granted owns the bus. The owner drives the shared data line and the shared jam line. A device that is granted but not requesting listens to those lines instead.

The data line changes meaning with the state of the jam line. With no collision, the owner puts its recovered NRZ stream on the line, regenerated preamble included. When two or more local ports are active at once, the owner raises jam and uses the data line to name the collision kind: 0 means multiport and 1 means single-port. The pins that go both ways are modelled as separate in, out and output-enable signals. A low expansion collision input from the arbiter starts a local jam sequence. That sequence drives an alternating pattern onto every local port for a minimum number of bit times and keeps going while the collision lasts.

Top module: `rptr_xbus_if`

## Requirements
- R1: While `rst` is high, and at the first clock edge under reset, `req_n` is 1. `dat_oe`, `jam_oe`, `jam_out`, `rx_valid` and every bit of `port_jam_en` are 0.
- R2: `req_n` goes to 0 at the clock edge after any bit of `port_act` is seen at 1. It returns to 1 at the first clock edge at which all bits of `port_act` are 0.
- R3: `dat_oe` and `jam_oe` are 1 exactly when `req_n` is 0 and `ack_n` is 0. They follow `ack_n` within the same cycle, so both are 0 whenever `ack_n` is 1.
- R4: When exactly one bit of `port_act` was set at the last clock edge, `dat_out` equals `nrz_in` as sampled at that edge and `jam_out` is 0.
- R5: When two or more bits of `port_act` were set at the last clock edge, `jam_out` is 1 and `dat_out` is 0 (multiport code).
- R6: When `ack_n` is 0 and `req_n` is 1 at a clock edge, then after that edge `rx_valid` is 1, `rx_data` equals the sampled `dat_in`, `rx_jam` equals the sampled `jam_in`, and `rx_multi` equals `jam_in AND NOT dat_in`.
- R7: When the listener condition of R6 does not hold at a clock edge, then after that edge `rx_valid`, `rx_data`, `rx_jam` and `rx_multi` are all 0.
- R8: If `xcol_n` is 0 at a clock edge while no jam is running, every bit of `port_jam_en` is 1 after that edge. `port_jam_d` starts at all ones and inverts on every following cycle of the jam.
- R9: A jam keeps `port_jam_en` high for exactly `JAM_MIN` cycles if `xcol_n` is low for only one edge. If `xcol_n` stays low longer, the jam ends at the first edge that samples `xcol_n` high, provided that edge comes after the minimum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous reset, active high |
| port_act | input | NPORTS | Per-port activity flags |
| nrz_in | input | 1 | Recovered NRZ data from the active port |
| ack_n | input | 1 | Arbiter acknowledge, active low |
| xcol_n | input | 1 | Expansion collision, active low |
| dat_in | input | 1 | Shared data line, input side |
| jam_in | input | 1 | Shared jam line, input side |
| req_n | output | 1 | Bus request, active low |
| dat_out | output | 1 | Shared data line, output value |
| dat_oe | output | 1 | Shared data line, output enable |
| jam_out | output | 1 | Shared jam line, output value |
| jam_oe | output | 1 | Shared jam line, output enable |
| rx_valid | output | 1 | Listener sample valid |
| rx_data | output | 1 | Listener data sample |
| rx_jam | output | 1 | Listener jam sample |
| rx_multi | output | 1 | Listener saw a multiport collision |
| port_jam_en | output | NPORTS | Per-port jam drive enable |
| port_jam_d | output | NPORTS | Per-port jam pattern bit |

## Verification
A wrong request register shows up one edge later as an output enable with the wrong polarity. It also makes a listener sample go missing or appear when it should not, so the error reaches `dat_oe` and `rx_valid` within a cycle. A fault in the multiport decode shows at the next edge as a wrong `jam_out` and `dat_out` pair. A jam counter that is off shows in the count of cycles that `port_jam_en` stays high, and that count is measured against `JAM_MIN` and against held collisions. A pattern register that fails to flip breaks the alternation of `port_jam_d` on the second cycle of a jam.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  typedef struct packed {
    logic valid;
    logic data;
    logic jam;
    logic multi;
  } xbus_rx_t;

  function automatic int unsigned cnt_w(input int unsigned maxval);
    return (maxval < 2) ? 1 : $clog2(maxval + 1);
  endfunction
endpackage

// File: rtl/xbus_req.sv
module xbus_req #(
  parameter int NPORTS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NPORTS-1:0] port_act,
  output logic              req_n,
  output logic              any_act,
  output logic              multi_act
);
  localparam int CW = $clog2(NPORTS + 1);

  logic [CW-1:0] act_cnt;

  always_comb begin
    act_cnt = '0;
    for (int i = 0; i < NPORTS; i++)
      act_cnt = act_cnt + CW'(port_act[i]);
  end

  assign any_act   = (act_cnt != '0);
  assign multi_act = (act_cnt > CW'(1));

  always_ff @(posedge clk) begin
    if (rst) req_n <= 1'b1;
    else     req_n <= ~any_act;
  end
endmodule

// File: rtl/xbus_steer.sv
module xbus_steer
  import xbus_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     req_n,
  input  logic     ack_n,
  input  logic     multi_act,
  input  logic     nrz_in,
  input  logic     dat_in,
  input  logic     jam_in,
  output logic     dat_out,
  output logic     jam_out,
  output logic     bus_oe,
  output xbus_rx_t rx
);
  logic listen;

  assign bus_oe = ~req_n & ~ack_n;
  assign listen = req_n & ~ack_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      dat_out <= 1'b0;
      jam_out <= 1'b0;
      rx      <= '0;
    end else begin
      jam_out     <= multi_act;
      dat_out     <= multi_act ? 1'b0 : nrz_in;
      rx.valid    <= listen;
      rx.data     <= listen & dat_in;
      rx.jam      <= listen & jam_in;
      rx.multi    <= listen & jam_in & ~dat_in;
    end
  end
endmodule

// File: rtl/xbus_jam.sv
module xbus_jam #(
  parameter int NPORTS  = 8,
  parameter int JAM_MIN = 96
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trig,
  output logic [NPORTS-1:0] jam_en,
  output logic [NPORTS-1:0] jam_d
);
  localparam int CW = xbus_pkg::cnt_w(JAM_MIN);

  logic          active;
  logic          pat;
  logic [CW-1:0] bits;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      pat    <= 1'b0;
      bits   <= '0;
    end else if (!active) begin
      if (trig) begin
        active <= 1'b1;
        pat    <= 1'b1;
        bits   <= CW'(1);
      end
    end else begin
      if (bits < CW'(JAM_MIN)) begin
        bits <= bits + CW'(1);
        pat  <= ~pat;
      end else if (!trig) begin
        active <= 1'b0;
        pat    <= 1'b0;
        bits   <= '0;
      end else begin
        pat <= ~pat;
      end
    end
  end

  for (genvar g = 0; g < NPORTS; g++) begin : g_port
    assign jam_en[g] = active;
    assign jam_d[g]  = pat;
  end
endmodule

// File: rtl/rptr_xbus_if.sv
module rptr_xbus_if
  import xbus_pkg::*;
#(
  parameter int NPORTS  = 8,
  parameter int JAM_MIN = 96
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NPORTS-1:0] port_act,
  input  logic              nrz_in,
  input  logic              ack_n,
  input  logic              xcol_n,
  input  logic              dat_in,
  input  logic              jam_in,
  output logic              req_n,
  output logic              dat_out,
  output logic              dat_oe,
  output logic              jam_out,
  output logic              jam_oe,
  output logic              rx_valid,
  output logic              rx_data,
  output logic              rx_jam,
  output logic              rx_multi,
  output logic [NPORTS-1:0] port_jam_en,
  output logic [NPORTS-1:0] port_jam_d
);
  logic     any_act;
  logic     multi_act;
  logic     bus_oe;
  xbus_rx_t rx;

  xbus_req #(.NPORTS(NPORTS)) u_req (
    .clk(clk), .rst(rst), .port_act(port_act),
    .req_n(req_n), .any_act(any_act), .multi_act(multi_act)
  );

  xbus_steer u_steer (
    .clk(clk), .rst(rst), .req_n(req_n), .ack_n(ack_n),
    .multi_act(multi_act), .nrz_in(nrz_in), .dat_in(dat_in), .jam_in(jam_in),
    .dat_out(dat_out), .jam_out(jam_out), .bus_oe(bus_oe), .rx(rx)
  );

  xbus_jam #(.NPORTS(NPORTS), .JAM_MIN(JAM_MIN)) u_jam (
    .clk(clk), .rst(rst), .trig(~xcol_n),
    .jam_en(port_jam_en), .jam_d(port_jam_d)
  );

  assign dat_oe   = bus_oe;
  assign jam_oe   = bus_oe;
  assign rx_valid = rx.valid;
  assign rx_data  = rx.data;
  assign rx_jam   = rx.jam;
  assign rx_multi = rx.multi;
endmodule

// File: rtl/rptr_xbus_if_chk.sv
module rptr_xbus_if_chk #(
  parameter int NPORTS  = 8,
  parameter int JAM_MIN = 96
) (
  input logic              clk,
  input logic              rst,
  input logic [NPORTS-1:0] port_act,
  input logic              nrz_in,
  input logic              ack_n,
  input logic              xcol_n,
  input logic              dat_in,
  input logic              req_n,
  input logic              dat_out,
  input logic              dat_oe,
  input logic              jam_out,
  input logic              jam_oe,
  input logic              rx_valid,
  input logic              rx_data,
  input logic [NPORTS-1:0] port_jam_en,
  input logic [NPORTS-1:0] port_jam_d
);
  localparam int CW = $clog2(JAM_MIN + 2);
  logic [CW-1:0] run_len;

  always_ff @(posedge clk) begin
    if (rst) run_len <= '0;
    else if (port_jam_en[0]) begin
      if (run_len < CW'(JAM_MIN + 1)) run_len <= run_len + CW'(1);
    end else run_len <= '0;
  end

  // R2
  req_on_chk: assert property (@(posedge clk) disable iff (rst)
    (port_act != '0) |=> !req_n);
  // R2
  req_off_chk: assert property (@(posedge clk) disable iff (rst)
    (port_act == '0) |=> req_n);
  // R3
  oe_idle_chk: assert property (@(posedge clk) disable iff (rst)
    ack_n |-> (!dat_oe && !jam_oe));
  // R4
  single_data_chk: assert property (@(posedge clk) disable iff (rst)
    ($countones(port_act) == 1) |=> (dat_out == $past(nrz_in)) && !jam_out);
  // R5
  multi_code_chk: assert property (@(posedge clk) disable iff (rst)
    ($countones(port_act) > 1) |=> (jam_out && !dat_out));
  // R6
  listen_chk: assert property (@(posedge clk) disable iff (rst)
    (!ack_n && req_n) |=> (rx_valid && (rx_data == $past(dat_in))));
  // R8
  jam_start_chk: assert property (@(posedge clk) disable iff (rst)
    (!xcol_n && port_jam_en == '0) |=> (&port_jam_en) && (&port_jam_d));
  // R8
  jam_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    (port_jam_en[0] && $past(port_jam_en[0])) |-> (port_jam_d[0] != $past(port_jam_d[0])));
  // R9
  jam_min_chk: assert property (@(posedge clk) disable iff (rst)
    (!port_jam_en[0] && $past(port_jam_en[0])) |-> (run_len >= CW'(JAM_MIN)));
endmodule

bind rptr_xbus_if rptr_xbus_if_chk #(.NPORTS(NPORTS), .JAM_MIN(JAM_MIN)) u_chk (
  .clk(clk), .rst(rst), .port_act(port_act), .nrz_in(nrz_in), .ack_n(ack_n),
  .xcol_n(xcol_n), .dat_in(dat_in), .req_n(req_n), .dat_out(dat_out),
  .dat_oe(dat_oe), .jam_out(jam_out), .jam_oe(jam_oe), .rx_valid(rx_valid),
  .rx_data(rx_data), .port_jam_en(port_jam_en), .port_jam_d(port_jam_d)
);

// File: tb/tb_rptr_xbus_if.sv
module tb_rptr_xbus_if;
  localparam int NP = 8;
  localparam int JM = 96;

  logic clk = 1'b0;
  logic rst;
  logic [NP-1:0] port_act;
  logic nrz_in, ack_n, xcol_n, dat_in, jam_in;
  logic req_n, dat_out, dat_oe, jam_out, jam_oe;
  logic rx_valid, rx_data, rx_jam, rx_multi;
  logic [NP-1:0] port_jam_en, port_jam_d;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  rptr_xbus_if #(.NPORTS(NP), .JAM_MIN(JM)) dut (
    .clk(clk), .rst(rst), .port_act(port_act), .nrz_in(nrz_in), .ack_n(ack_n),
    .xcol_n(xcol_n), .dat_in(dat_in), .jam_in(jam_in), .req_n(req_n),
    .dat_out(dat_out), .dat_oe(dat_oe), .jam_out(jam_out), .jam_oe(jam_oe),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_jam(rx_jam), .rx_multi(rx_multi),
    .port_jam_en(port_jam_en), .port_jam_d(port_jam_d)
  );

  typedef struct packed {
    logic [7:0] act;
    logic ack_n, nrz, din, jin;
    logic e_req_n, e_oe, e_dout, e_jout, e_rxv, e_rxd, e_rxm;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{8'h00, 1'b0, 1'b0, 1'b1, 1'b0,  1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
    '{8'h00, 1'b0, 1'b0, 1'b0, 1'b1,  1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
    '{8'h01, 1'b1, 1'b1, 1'b0, 1'b0,  1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    '{8'h01, 1'b0, 1'b0, 1'b0, 1'b0,  1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{8'h01, 1'b0, 1'b1, 1'b0, 1'b0,  1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    '{8'h05, 1'b0, 1'b1, 1'b0, 1'b0,  1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    '{8'h80, 1'b0, 1'b1, 1'b0, 1'b0,  1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    '{8'h00, 1'b0, 1'b1, 1'b1, 1'b0,  1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    '{8'h00, 1'b0, 1'b0, 1'b1, 1'b1,  1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
    '{8'hFF, 1'b0, 1'b1, 1'b0, 1'b0,  1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int len;
    rst = 1'b1; port_act = '0; nrz_in = 0; ack_n = 1; xcol_n = 1; dat_in = 0; jam_in = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1", "req_n", req_n, 1);
    chk("R1", "dat_oe", dat_oe, 0);
    chk("R1", "jam_oe", jam_oe, 0);
    chk("R1", "jam_out", jam_out, 0);
    chk("R1", "rx_valid", rx_valid, 0);
    chk("R1", "port_jam_en", port_jam_en, 0);
    rst = 1'b0;
    @(negedge clk);

    // R2 R3 R4 R5 R6 R7 vector walk
    for (int i = 0; i < NV; i++) begin
      port_act = VECS[i].act; ack_n = VECS[i].ack_n; nrz_in = VECS[i].nrz;
      dat_in = VECS[i].din; jam_in = VECS[i].jin;
      @(negedge clk);
      chk("R2", $sformatf("v%0d req_n", i), req_n, VECS[i].e_req_n);
      chk("R3", $sformatf("v%0d dat_oe", i), dat_oe, VECS[i].e_oe);
      chk("R3", $sformatf("v%0d jam_oe", i), jam_oe, VECS[i].e_oe);
      chk("R4", $sformatf("v%0d dat_out", i), dat_out, VECS[i].e_dout);
      chk("R5", $sformatf("v%0d jam_out", i), jam_out, VECS[i].e_jout);
      chk("R6", $sformatf("v%0d rx_valid", i), rx_valid, VECS[i].e_rxv);
      chk("R7", $sformatf("v%0d rx_data", i), rx_data, VECS[i].e_rxd);
      chk("R6", $sformatf("v%0d rx_multi", i), rx_multi, VECS[i].e_rxm);
    end

    // R3 enable drops in the same cycle as acknowledge is released
    #1 ack_n = 1'b1;
    #1 chk("R3", "oe follows ack_n", {dat_oe, jam_oe}, 2'b00);
    @(negedge clk);
    // R7 owner side: nothing captured on the listener outputs
    chk("R7", "rx_valid while requesting", rx_valid, 0);
    chk("R7", "rx_jam while requesting", rx_jam, 0);
    port_act = '0; ack_n = 1'b1;
    @(negedge clk);

    // R8 R9 minimum jam
    xcol_n = 1'b0;
    @(negedge clk);
    xcol_n = 1'b1;
    chk("R8", "jam_en all ones", port_jam_en, {NP{1'b1}});
    chk("R8", "first pattern", port_jam_d, {NP{1'b1}});
    @(negedge clk);
    chk("R8", "second pattern", port_jam_d, {NP{1'b0}});
    len = 2;
    while (port_jam_en[0] && len < 1000) begin
      @(negedge clk);
      if (port_jam_en[0]) len++;
    end
    chk("R9", "minimum jam length", len, JM);

    // R9 extended jam while collision is held
    repeat (2) @(negedge clk);
    xcol_n = 1'b0;
    repeat (150) @(negedge clk);
    xcol_n = 1'b1;
    chk("R9", "still jamming when held", port_jam_en[0], 1);
    len = 150;
    while (port_jam_en[0] && len < 1000) begin
      @(negedge clk);
      if (port_jam_en[0]) len++;
    end
    chk("R9", "held jam length", len, 150);

    // R1 synchronous reset clears a running jam and request
    port_act = 8'h02;
    xcol_n = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R1", "reset clears jam", port_jam_en, 0);
    chk("R1", "reset releases req_n", req_n, 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule